// File: doc/BRIEF.md
# Configurable Divided-Clock Output Router

This block derives a family of clocks from two source clocks and steers them onto six outputs. Each of the two divider banks runs on its own source clock and produces three derived clocks. The first is a division by a programmable ratio. The other two are fixed ratios: /2 and /3 on bank one, /2 and /4 on bank two. Each output has a 3-bit source code. The code picks the reference clock, one of the six derived clocks, or nothing. A per-output enable bit then gates the chosen clock.

Software-style configuration arrives as byte writes on a plain write strobe in the reference clock domain. The six source codes are packed back to back, most significant bit first, across three consecutive bytes. The enables sit in a byte of their own. A new programmable ratio never cuts a divided clock short. The divider adopts it only at the start of its next period. The configuration is expected to be quasi-static with respect to the bank clocks. There is no data stream through the block, so there is no valid/ready interface and every pin is plain control or clock.

Top module: `clksel_fabric`

## Requirements
- R1: After reset every output is low, both programmable ratios are 8, every source code is 000 and every enable bit is 0.
- R2: Source code 000 drives the output with the reference clock, following both its high and its low phase.
- R3: Codes 001, 010 and 011 select bank one divided by its programmable ratio, by 2 and by 3 respectively.
- R4: Codes 100, 101 and 110 select bank two divided by its programmable ratio, by 2 and by 4 respectively.
- R5: A divider of ratio N repeats every N source-clock rising edges. Each period begins with a rising output at a source edge and is high for ceil(N/2) edges and low for floor(N/2) edges. The first source edge after reset release starts a period.
- R6: An output whose source code is 111 stays low.
- R7: Bit k of the enable byte (k = 0..5) enables output k+1, and a 0 holds that output low. Bits 7 and 6 of the enable byte have no effect.
- R8: A ratio write uses data bits 6:0 and ignores bit 7. A value below 4 is stored as 4.
- R9: A divider adopts a newly written ratio only at the rising output edge that begins its next period, so the period in progress completes at the old ratio.
- R10: Address map: 0 is the bank-one ratio, 1 is the bank-two ratio, 2 to 4 are the source-code bytes, and 5 is the enable byte. The 18 code bits are read from the 24-bit value {byte@2, byte@3, byte@4}. Output 1 takes bits 23:21, output 2 takes 20:18, and so on, with output k taking bits 23-3(k-1) down to 21-3(k-1). Bits 5:0 of the byte at address 4 are ignored.
- R11: A write is captured at the reference clock rising edge where the strobe is high. A new source code or enable acts on the output immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the configuration registers |
| bank1_clk | input | 1 | Source clock of divider bank one |
| bank2_clk | input | 1 | Source clock of divider bank two |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| clk_out | output | 6 | Routed and gated clocks; bit 0 is output 1 |

## Verification
On every cycle the assertions check the following. Reserved codes and cleared enables force their outputs low. Stored ratios never fall below 4 after a write. The fixed /2, /3 and /4 taps keep their shapes. A programmable divider changes its live ratio only on a rising edge of its own output. The bench's scenarios must show the rest: that each code reaches the intended tap, that odd ratios give the longer high phase, that a mid-period ratio write lets the current period finish, and that the packing across byte boundaries places each code where it belongs. They also show that padding and unused enable bits have no effect, which only a reference model compared against the outputs cycle by cycle can reveal.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  // source codes carried by each output's selector field
  typedef enum logic [2:0] {
    SRC_REF  = 3'd0,
    SRC_B1_N = 3'd1,
    SRC_B1_A = 3'd2,
    SRC_B1_B = 3'd3,
    SRC_B2_N = 3'd4,
    SRC_B2_A = 3'd5,
    SRC_B2_B = 3'd6,
    SRC_NONE = 3'd7
  } src_e;

  localparam int unsigned DIV_MIN  = 4;  // smallest accepted programmable ratio
  localparam int unsigned DIV_SAFE = 8;  // ratio loaded at reset
endpackage

// File: rtl/clksel_div.sv
module clksel_div #(
  parameter int unsigned NW    = 7,
  parameter int unsigned RST_N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_req,
  output logic          div_q
);
  logic [NW-1:0] cnt;
  logic [NW-1:0] n_cur;
  logic [NW:0]   cnt_nx;
  logic [NW:0]   half;
  logic          wrap;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign half   = ({1'b0, n_cur} + 1'b1) >> 1;
  assign wrap   = (cnt_nx == {1'b0, n_cur});

  // a period starts with the rising edge; the ratio is sampled only there
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= NW'(RST_N - 1);
      n_cur <= NW'(RST_N);
      div_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      n_cur <= n_req;
      div_q <= 1'b1;
    end else begin
      cnt   <= cnt_nx[NW-1:0];
      div_q <= (cnt_nx < half);
    end
  end
endmodule

// File: rtl/clksel_bank.sv
module clksel_bank #(
  parameter int unsigned NW    = 7,
  parameter int unsigned RST_N = 8,
  parameter int unsigned FIX_A = 2,
  parameter int unsigned FIX_B = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_sel,
  output logic [2:0]    taps
);
  localparam int unsigned NFIX = 2;

  clksel_div #(.NW(NW), .RST_N(RST_N)) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .n_req (n_sel),
    .div_q (taps[0])
  );

  for (genvar f = 0; f < NFIX; f++) begin : g_fix
    localparam int unsigned FN = (f == 0) ? FIX_A : FIX_B;
    clksel_div #(.NW(NW), .RST_N(FN)) u_fix (
      .clk   (clk),
      .rst_n (rst_n),
      .n_req (NW'(FN)),
      .div_q (taps[f+1])
    );
  end
endmodule

// File: rtl/clksel_cfg.sv
module clksel_cfg #(
  parameter int unsigned NW   = 7,
  parameter int unsigned NOUT = 6,
  parameter int unsigned SELW = 3,
  parameter int unsigned AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output logic [NW-1:0]        n1,
  output logic [NW-1:0]        n2,
  output logic [NOUT*SELW-1:0] sel_flat,
  output logic [NOUT-1:0]      en
);
  import clksel_pkg::*;

  localparam int unsigned SELTOT = NOUT * SELW;
  localparam int unsigned NSELB  = (SELTOT + 7) / 8;
  localparam int unsigned A_N1   = 0;
  localparam int unsigned A_N2   = 1;
  localparam int unsigned A_SEL  = 2;
  localparam int unsigned A_EN   = A_SEL + NSELB;

  logic [NW-1:0] wnum;
  logic [NW-1:0] nclamp;

  assign wnum   = wdata[NW-1:0];
  assign nclamp = (wnum < NW'(DIV_MIN)) ? NW'(DIV_MIN) : wnum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n1       <= NW'(DIV_SAFE);
      n2       <= NW'(DIV_SAFE);
      sel_flat <= '0;
      en       <= '0;
    end else if (we) begin
      if (addr == AW'(A_N1)) n1 <= nclamp;
      if (addr == AW'(A_N2)) n2 <= nclamp;
      if (addr == AW'(A_EN)) en <= wdata[NOUT-1:0];
      // field bit p sits at MSB-first stream position g across the code bytes
      for (int p = 0; p < SELTOT; p++) begin
        if (addr == AW'(A_SEL + (SELTOT - 1 - p) / 8))
          sel_flat[p] <= wdata[7 - ((SELTOT - 1 - p) % 8)];
      end
    end
  end
endmodule

// File: rtl/clksel_slot.sv
module clksel_slot #(
  parameter int unsigned SELW = 3
) (
  input  logic [SELW-1:0]        sel,
  input  logic                   en,
  input  logic [(1<<SELW)-1:0]   taps,
  output logic                   out
);
  logic rsvd;
  assign rsvd = (sel == '1);
  assign out  = en & ~rsvd & taps[sel];
endmodule

// File: rtl/clksel_fabric.sv
module clksel_fabric #(
  parameter int unsigned NOUT  = 6,
  parameter int unsigned SELW  = 3,
  parameter int unsigned NW    = 7,
  parameter int unsigned AW    = 3,
  parameter int unsigned B1_FA = 2,
  parameter int unsigned B1_FB = 3,
  parameter int unsigned B2_FA = 2,
  parameter int unsigned B2_FB = 4
) (
  input  logic            ref_clk,
  input  logic            bank1_clk,
  input  logic            bank2_clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [NOUT-1:0] clk_out
);
  import clksel_pkg::*;

  localparam int unsigned SELTOT = NOUT * SELW;
  localparam int unsigned NTAP   = 1 << SELW;

  logic [NW-1:0]     n1_cfg;
  logic [NW-1:0]     n2_cfg;
  logic [SELTOT-1:0] sel_flat;
  logic [NOUT-1:0]   en_q;
  logic [2:0]        b1_taps;
  logic [2:0]        b2_taps;
  logic [NTAP-1:0]   tapv;

  clksel_cfg #(.NW(NW), .NOUT(NOUT), .SELW(SELW), .AW(AW)) u_cfg (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .n1       (n1_cfg),
    .n2       (n2_cfg),
    .sel_flat (sel_flat),
    .en       (en_q)
  );

  clksel_bank #(.NW(NW), .RST_N(DIV_SAFE), .FIX_A(B1_FA), .FIX_B(B1_FB)) u_bank1 (
    .clk   (bank1_clk),
    .rst_n (rst_n),
    .n_sel (n1_cfg),
    .taps  (b1_taps)
  );

  clksel_bank #(.NW(NW), .RST_N(DIV_SAFE), .FIX_A(B2_FA), .FIX_B(B2_FB)) u_bank2 (
    .clk   (bank2_clk),
    .rst_n (rst_n),
    .n_sel (n2_cfg),
    .taps  (b2_taps)
  );

  always_comb begin
    tapv                 = '0;
    tapv[int'(SRC_REF)]  = ref_clk;
    tapv[int'(SRC_B1_N)] = b1_taps[0];
    tapv[int'(SRC_B1_A)] = b1_taps[1];
    tapv[int'(SRC_B1_B)] = b1_taps[2];
    tapv[int'(SRC_B2_N)] = b2_taps[0];
    tapv[int'(SRC_B2_A)] = b2_taps[1];
    tapv[int'(SRC_B2_B)] = b2_taps[2];
    tapv[int'(SRC_NONE)] = 1'b0;
  end

  // output 1 owns the most significant selector field
  for (genvar k = 0; k < NOUT; k++) begin : g_slot
    clksel_slot #(.SELW(SELW)) u_slot (
      .sel  (sel_flat[SELTOT-1-k*SELW -: SELW]),
      .en   (en_q[k]),
      .taps (tapv),
      .out  (clk_out[k])
    );
  end
endmodule

// File: rtl/clksel_fabric_chk.sv
module clksel_fabric_chk #(
  parameter int unsigned NOUT = 6,
  parameter int unsigned SELW = 3,
  parameter int unsigned NW   = 7,
  parameter int unsigned AW   = 3
) (
  input logic                 ref_clk,
  input logic                 bank1_clk,
  input logic                 bank2_clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [AW-1:0]        cfg_addr,
  input logic [NOUT*SELW-1:0] sel_flat,
  input logic [NOUT-1:0]      en_q,
  input logic [NOUT-1:0]      clk_out,
  input logic [NW-1:0]        n1_cfg,
  input logic [NW-1:0]        n2_cfg,
  input logic [2:0]           b1_taps,
  input logic [2:0]           b2_taps,
  input logic [NW-1:0]        n1_live,
  input logic [NW-1:0]        n2_live
);
  localparam int unsigned SELTOT = NOUT * SELW;

  logic [1:0] arm1;
  logic [1:0] arm2;
  logic       armed1;
  logic       armed2;

  always_ff @(posedge bank1_clk or negedge rst_n)
    if (!rst_n) arm1 <= '0;
    else if (arm1 != 2'd2) arm1 <= arm1 + 2'd1;

  always_ff @(posedge bank2_clk or negedge rst_n)
    if (!rst_n) arm2 <= '0;
    else if (arm2 != 2'd2) arm2 <= arm2 + 2'd1;

  assign armed1 = (arm1 == 2'd2);
  assign armed2 = (arm2 == 2'd2);

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assert_rsvd_low_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (sel_flat[SELTOT-1-k*SELW -: SELW] == '1) |-> !clk_out[k]);
    assert_disabled_low_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !en_q[k] |-> !clk_out[k]);
  end

  assert_n1_clamped_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(0)) |=> (n1_cfg >= NW'(4)));
  assert_n2_clamped_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(1)) |=> (n2_cfg >= NW'(4)));

  assert_b1_half_toggles_R3: assert property (@(posedge bank1_clk) disable iff (!rst_n || !armed1)
    b1_taps[1] != $past(b1_taps[1]));
  assert_b1_third_shape_R3: assert property (@(posedge bank1_clk) disable iff (!rst_n || !armed1)
    !b1_taps[2] |=> b1_taps[2]);
  assert_b2_half_toggles_R4: assert property (@(posedge bank2_clk) disable iff (!rst_n || !armed2)
    b2_taps[1] != $past(b2_taps[1]));
  assert_b2_quarter_shape_R4: assert property (@(posedge bank2_clk) disable iff (!rst_n || !armed2)
    (b2_taps[2] && $past(b2_taps[2])) |=> !b2_taps[2]);

  assert_b1_ratio_on_rise_R9: assert property (@(posedge bank1_clk) disable iff (!rst_n || !armed1)
    !$stable(n1_live) |-> $rose(b1_taps[0]));
  assert_b2_ratio_on_rise_R9: assert property (@(posedge bank2_clk) disable iff (!rst_n || !armed2)
    !$stable(n2_live) |-> $rose(b2_taps[0]));
endmodule

bind clksel_fabric clksel_fabric_chk #(.NOUT(NOUT), .SELW(SELW), .NW(NW), .AW(AW)) u_chk (
  .ref_clk   (ref_clk),
  .bank1_clk (bank1_clk),
  .bank2_clk (bank2_clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .sel_flat  (sel_flat),
  .en_q      (en_q),
  .clk_out   (clk_out),
  .n1_cfg    (n1_cfg),
  .n2_cfg    (n2_cfg),
  .b1_taps   (b1_taps),
  .b2_taps   (b2_taps),
  .n1_live   (u_bank1.u_prog.n_cur),
  .n2_live   (u_bank2.u_prog.n_cur)
);

// File: tb/sim_clksel_fabric.sv
module sim_clksel_fabric;
  localparam int CLK_PERIOD = 20;
  localparam int QTR        = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [5:0] clk_out;

  int nvec = 0;
  int nerr = 0;
  int cur_req = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  clksel_fabric u0 (
    .ref_clk   (clk),
    .bank1_clk (clk),
    .bank2_clk (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .clk_out   (clk_out)
  );

  // reference model built from the requirements; divider slots:
  // 0 bank1/N, 1 bank1/2, 2 bank1/3, 3 bank2/N, 4 bank2/2, 5 bank2/4
  int         m_n [6];
  int         m_p [6];
  bit         m_q [6];
  int         sh_n1, sh_n2;
  logic [7:0] sh_b [3];
  logic [5:0] sh_en;

  logic [5:0] exp_q [$];
  int         tag_q [$];

  task automatic model_reset();
    int base [6] = '{8, 2, 3, 8, 2, 4};
    for (int d = 0; d < 6; d++) begin
      m_n[d] = base[d];
      m_p[d] = base[d] - 1;
      m_q[d] = 1'b0;
    end
    sh_n1 = 8; sh_n2 = 8;
    for (int b = 0; b < 3; b++) sh_b[b] = 8'h00;
    sh_en = '0;
  endtask

  function automatic logic [5:0] model_out();
    logic [23:0] img;
    logic [5:0]  v;
    img = {sh_b[0], sh_b[1], sh_b[2]};
    for (int k = 0; k < 6; k++) begin
      logic [2:0] s;
      logic       t;
      s = img[23-3*k -: 3];
      if (s == 3'd0)      t = 1'b1;   // reference is high at the sample point
      else if (s == 3'd7) t = 1'b0;
      else                t = m_q[s-1];
      v[k] = t & sh_en[k];
    end
    return v;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int d = 0; d < 6; d++) begin
        if (m_p[d] == m_n[d] - 1) begin
          m_p[d] = 0;
          if (d == 0) m_n[d] = sh_n1;
          if (d == 3) m_n[d] = sh_n2;
          m_q[d] = 1'b1;
        end else begin
          m_p[d] = m_p[d] + 1;
          m_q[d] = (m_p[d] < (m_n[d] + 1) / 2);
        end
      end
      if (cfg_we) begin
        int v;
        v = int'(cfg_wdata & 8'h7F);
        if (v < 4) v = 4;
        case (cfg_addr)
          3'd0: sh_n1 = v;
          3'd1: sh_n2 = v;
          3'd2: sh_b[0] = cfg_wdata;
          3'd3: sh_b[1] = cfg_wdata;
          3'd4: sh_b[2] = cfg_wdata;
          3'd5: sh_en = cfg_wdata[5:0];
          default: ;
        endcase
      end
      exp_q.push_back(model_out());
      tag_q.push_back(cur_req);
    end
  end

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(QTR);
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      int         t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nvec++;
      if (clk_out !== e) begin
        nerr++;
        $display("FAIL R%0d clk_out actual=%b expected=%b at %0t", t, clk_out, e, $time);
      end
    end
  end

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL R0 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state, outputs low while held and after release
    cur_req = 1;
    idle(3);
    check("R1 during reset", clk_out, 6'b000000);
    rst_n = 1'b1;
    idle(6);

    // R2 / R7: enable all with code 000; low phase of reference must show
    cur_req = 2;
    wr(3'd5, 8'h3F);
    idle(3);
    @(posedge clk); #(3*QTR);
    check("R2 reference low phase", clk_out, 6'b000000);
    idle(3);

    // R3 R4 R10 R11: codes 1..6 on outputs 1..6, junk in padding bits
    cur_req = 3;
    wr(3'd0, 8'd5);
    wr(3'd1, 8'd6);
    wr(3'd2, 8'h29);
    wr(3'd3, 8'hCB);
    cur_req = 10;
    wr(3'd4, 8'h95);
    cur_req = 4;
    idle(40);

    // R5: odd ratios on both programmable dividers
    cur_req = 5;
    wr(3'd0, 8'd7);
    wr(3'd1, 8'd9);
    idle(45);

    // R9: ratio change in the middle of a period
    cur_req = 9;
    idle(3);
    wr(3'd0, 8'd4);
    idle(2);
    wr(3'd1, 8'd5);
    idle(30);

    // R8: clamp below 4 and bit 7 ignored
    cur_req = 8;
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h8A);
    idle(40);

    // R6: output 1 given the reserved code
    cur_req = 6;
    wr(3'd2, 8'hE9);
    idle(12);

    // R7: only outputs 1, 3, 5 enabled; bits 7:6 set but ignored
    cur_req = 7;
    wr(3'd5, 8'hD5);
    idle(20);

    // R10: output 3 = 011 and output 6 = 101 straddle byte boundaries
    cur_req = 10;
    wr(3'd5, 8'h3F);
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h81);
    wr(3'd4, 8'h55);
    idle(30);

    // R11: a selector write acts right after its capturing edge
    cur_req = 11;
    wr(3'd2, 8'h20);
    wr(3'd5, 8'h01);
    idle(12);

    idle(2);
    finish_run();
  end
endmodule